// File: doc/BRIEF.md
# Multi-format PCM serial audio receiver

This block turns a three-wire stereo PCM stream into parallel samples. The wires are a bit clock, a word clock that tells the left half of a frame from the right half, and a serial data line. All three are sampled in the system clock domain, and the bit clock is expected to be several times slower than the system clock. A 3-bit format code selects the justification and the word length. Each delivered sample is sign-extended to 24 bits. A one-cycle strobe marks a new stereo pair.

The receiver also watches the word clock against the system clock. It learns the frame period in system-clock cycles and then runs a free-wheeling phase counter. At every rising word-clock edge it measures how far the edge has moved from the expected phase. When the shift is larger than six bit-clock periods, the block flags a loss of synchronization. It then forces both outputs to zero and relearns the frame period from that edge onwards.

Top module: `pcm_serial_rx`

## Requirements
- R1: Serial data is taken on each rising edge of the bit clock, most significant bit first, and is treated as two's complement.
- R2: Format code on `fmt`: 000 = I2S 24-bit, 001 = I2S 16-bit, 010 = left-justified 24-bit, 011 = left-justified 20-bit, 100 = left-justified 16-bit, 101 = right-justified 24-bit, 110 = right-justified 20-bit, 111 = right-justified 16-bit. The all-zero code gives 24-bit I2S.
- R3: In I2S formats the left word is sent while the word clock is low and the right word while it is high. The MSB arrives on the second bit clock after the word-clock edge.
- R4: In left-justified formats the left word is sent while the word clock is high. The MSB arrives on the first bit clock after the word-clock edge, and the bits after the word are ignored.
- R5: In right-justified formats the left word is sent while the word clock is high. The LSB is the last bit before the next word-clock edge, and only the last N bits of the half count.
- R6: Words of 16 and 20 bits are sign-extended to 24 bits on `left_o` and `right_o`.
- R7: `valid_o` is a single-cycle pulse, once per stereo frame, after the right word is complete. `left_o` and `right_o` both change with it and carry that frame's left and right words.
- R8: When a rising word-clock edge is more than six bit-clock periods away from the learned phase, `sync_lost_o` pulses once. From the following cycle `left_o` and `right_o` are zero and no `valid_o` is given until the receiver relocks.
- R9: A phase shift of six bit-clock periods or less raises no `sync_lost_o`.
- R10: After a loss, the edge that caused it starts a new period measurement. Delivery resumes with the frame whose right word follows the next rising word-clock edge.
- R11: After reset the outputs are zero and `valid_o` is low. The first delivered frame is the one whose right word completes after the second rising word-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bck | input | 1 | Serial bit clock, synchronous to clk |
| lrck | input | 1 | Word clock (left/right select) |
| sdata | input | 1 | Serial audio data |
| fmt | input | 3 | Format and word-length code (see R2) |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe for a new stereo pair |
| sync_lost_o | output | 1 | One-cycle pulse on word-clock phase drift |

## Verification
Every one of the eight format codes runs a stream of 64-bit frames. The frames carry mixed-sign words, plus one frame with the most negative and most positive value for that word length. A wrong bit offset, a swapped word-clock polarity, a missed sign extension or a bit taken on the falling edge shows up as a pair that differs from the reference. The index of the first delivered frame in each run shows whether locking after reset takes exactly two rising word-clock edges. A separate I2S run stretches one frame by exactly six bit clocks, which must not trip the drift check, and a later frame by one bit more, which must. After that loss the run confirms that the outputs read zero, that one frame is withheld, and which frame index comes out next.

// File: rtl/pcm_rx_pkg.sv
// Shared types for the PCM serial receiver: justification kinds and the
// decoded format record. Assumes the 3-bit code is static while streaming.
package pcm_rx_pkg;

    typedef enum logic [1:0] {
        JUST_I2S   = 2'd0,
        JUST_LEFT  = 2'd1,
        JUST_RIGHT = 2'd2
    } just_e;

    typedef struct packed {
        just_e      just;
        logic [4:0] wlen;
    } fmt_t;

    // Map the format code onto justification and word length.
    function automatic fmt_t decode_fmt(input logic [2:0] code);
        fmt_t f;
        case (code)
            3'd0:    begin f.just = JUST_I2S;   f.wlen = 5'd24; end
            3'd1:    begin f.just = JUST_I2S;   f.wlen = 5'd16; end
            3'd2:    begin f.just = JUST_LEFT;  f.wlen = 5'd24; end
            3'd3:    begin f.just = JUST_LEFT;  f.wlen = 5'd20; end
            3'd4:    begin f.just = JUST_LEFT;  f.wlen = 5'd16; end
            3'd5:    begin f.just = JUST_RIGHT; f.wlen = 5'd24; end
            3'd6:    begin f.just = JUST_RIGHT; f.wlen = 5'd20; end
            default: begin f.just = JUST_RIGHT; f.wlen = 5'd16; end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
// Samples the serial port into the system clock domain and finds bit-clock
// and word-clock rising edges. Assumes the port is synchronous to clk and
// that data and word clock are stable around the bit-clock rising edge.
module pcm_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bck,
    input  logic lrck,
    input  logic sdata,
    output logic bit_stb,
    output logic bit_val,
    output logic lr_lvl,
    output logic lr_rise
);
    logic bck_q, bck_qq, lr_q, lr_qq, sd_q;

    // Two-deep history of the port pins for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_q  <= 1'b0;
            bck_qq <= 1'b0;
            lr_q   <= 1'b0;
            lr_qq  <= 1'b0;
            sd_q   <= 1'b0;
        end else begin
            bck_q  <= bck;
            bck_qq <= bck_q;
            lr_q   <= lrck;
            lr_qq  <= lr_q;
            sd_q   <= sdata;
        end
    end

    assign bit_stb = bck_q & ~bck_qq;
    assign bit_val = sd_q;
    assign lr_lvl  = lr_q;
    assign lr_rise = lr_q & ~lr_qq;

endmodule

// File: rtl/pcm_rx_deser.sv
// Counts bits inside each word-clock half, picks out the word at the
// position the format places it, and sign-extends it. Assumes each half is
// longer than the selected word length.
module pcm_rx_deser
    import pcm_rx_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              lr_lvl,
    input  fmt_t              fmt,
    output logic              word_stb,
    output logic [DATA_W-1:0] word,
    output logic              word_left
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              lr_prev;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;

    logic              lr_edge, take, chan_lvl, left_c;
    logic [CNT_W-1:0]  idx, wlen_c;
    logic [DATA_W-1:0] shifted, raw, ext;

    // Decide whether this bit closes a word, and which channel it is.
    always_comb begin
        lr_edge = lr_lvl ^ lr_prev;
        idx     = lr_edge ? '0 : cnt;
        wlen_c  = CNT_W'(fmt.wlen);
        shifted = {shreg[DATA_W-2:0], bit_val};
        case (fmt.just)
            JUST_RIGHT: begin take = lr_edge;                     raw = shreg;   chan_lvl = lr_prev; end
            JUST_LEFT:  begin take = (idx == wlen_c - CNT_W'(1)); raw = shifted; chan_lvl = lr_lvl;  end
            default:    begin take = (idx == wlen_c);             raw = shifted; chan_lvl = lr_lvl;  end
        endcase
        left_c = (fmt.just == JUST_I2S) ? ~chan_lvl : chan_lvl;
    end

    // Sign-extend the low wlen bits of the raw word.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            ext[i] = (i < int'(fmt.wlen)) ? raw[i] : raw[fmt.wlen - 5'd1];
        end
    end

    // Shift, count and capture on each bit-clock rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_prev   <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            word_stb  <= 1'b0;
            word      <= '0;
            word_left <= 1'b0;
        end else begin
            word_stb <= 1'b0;
            if (bit_stb) begin
                shreg   <= shifted;
                lr_prev <= lr_lvl;
                cnt     <= lr_edge ? CNT_W'(1) : ((cnt == CNT_MAX) ? cnt : cnt + CNT_W'(1));
                if (take) begin
                    word_stb  <= 1'b1;
                    word      <= ext;
                    word_left <= left_c;
                end
            end
        end
    end

    // R1
    stb_follows_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> $past(bit_stb));

endmodule

// File: rtl/pcm_rx_drift.sv
// Learns the word-clock period in system-clock cycles and the bit-clock
// period, then checks every rising word-clock edge against a free-running
// phase counter. Assumes periods fit in PH_W bits.
module pcm_rx_drift #(
    parameter int PH_W      = 16,
    parameter int DRIFT_BCK = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_rise,
    input  logic lr_rise,
    output logic locked,
    output logic sync_lost
);
    localparam logic [PH_W-1:0] PH_MAX = '1;

    typedef enum logic [1:0] {ST_WAIT, ST_MEAS, ST_LOCK} st_e;

    st_e             st;
    logic [PH_W-1:0] ph, per, bcnt, bper, thr;
    logic            drift_bad;

    assign thr       = bper * PH_W'(DRIFT_BCK);
    assign drift_bad = (ph > thr) && ((per - ph) > thr);
    assign locked    = (st == ST_LOCK);

    // Track the bit-clock period in system-clock cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= '0;
            bper <= '0;
        end else if (bck_rise) begin
            bper <= bcnt;
            bcnt <= PH_W'(1);
        end else begin
            bcnt <= (bcnt == PH_MAX) ? bcnt : bcnt + PH_W'(1);
        end
    end

    // Measure, lock and supervise the word-clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_WAIT;
            ph        <= '0;
            per       <= '0;
            sync_lost <= 1'b0;
        end else begin
            sync_lost <= 1'b0;
            case (st)
                ST_WAIT: if (lr_rise) begin
                    st <= ST_MEAS;
                    ph <= PH_W'(1);
                end
                ST_MEAS: begin
                    ph <= (ph == PH_MAX) ? ph : ph + PH_W'(1);
                    if (lr_rise) begin
                        per <= ph;
                        ph  <= PH_W'(1);
                        st  <= ST_LOCK;
                    end
                end
                default: begin
                    ph <= (ph == per - PH_W'(1)) ? '0 : ph + PH_W'(1);
                    if (lr_rise && drift_bad) begin
                        st        <= ST_MEAS;
                        ph        <= PH_W'(1);
                        sync_lost <= 1'b1;
                    end
                end
            endcase
        end
    end

    // R8
    lost_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |-> !locked);
    // R11
    lock_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(lr_rise));
    // R9
    lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !lr_rise) |=> locked);

endmodule

// File: rtl/pcm_serial_rx.sv
// Top of the PCM serial receiver: decodes the format, deserializes words,
// pairs left with right and mutes the outputs while word-clock phase is not
// locked. Assumes all port inputs are synchronous to clk.
module pcm_serial_rx
    import pcm_rx_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int CNT_W     = 6,
    parameter int PH_W      = 16,
    parameter int DRIFT_BCK = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck,
    input  logic              lrck,
    input  logic              sdata,
    input  logic [2:0]        fmt,
    output logic [DATA_W-1:0] left_o,
    output logic [DATA_W-1:0] right_o,
    output logic              valid_o,
    output logic              sync_lost_o
);
    fmt_t              fmt_d;
    logic              bit_stb, bit_val, lr_lvl, lr_rise;
    logic              word_stb, word_left, locked;
    logic [DATA_W-1:0] word, pend;

    assign fmt_d = decode_fmt(fmt);

    pcm_rx_sync sync_i (
        .clk(clk), .rst_n(rst_n), .bck(bck), .lrck(lrck), .sdata(sdata),
        .bit_stb(bit_stb), .bit_val(bit_val), .lr_lvl(lr_lvl), .lr_rise(lr_rise)
    );

    pcm_rx_deser #(.DATA_W(DATA_W), .CNT_W(CNT_W)) deser_i (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .lr_lvl(lr_lvl), .fmt(fmt_d), .word_stb(word_stb), .word(word),
        .word_left(word_left)
    );

    pcm_rx_drift #(.PH_W(PH_W), .DRIFT_BCK(DRIFT_BCK)) drift_i (
        .clk(clk), .rst_n(rst_n), .bck_rise(bit_stb), .lr_rise(lr_rise),
        .locked(locked), .sync_lost(sync_lost_o)
    );

    // Hold the left word, then publish the pair when the right word lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= '0;
            left_o  <= '0;
            right_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (word_stb && word_left) begin
                pend <= word;
            end
            if (!locked) begin
                left_o  <= '0;
                right_o <= '0;
            end else if (word_stb && !word_left) begin
                left_o  <= pend;
                right_o <= word;
                valid_o <= 1'b1;
            end
        end
    end

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R8
    mute_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> (!valid_o && left_o == '0 && right_o == '0));

endmodule

// File: tb/pcm_serial_rx_tb_top.sv
// Bench: drives framed serial audio in every format, keeps a queue of the
// pairs the requirements say must appear, and compares on every clock.
module pcm_serial_rx_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0, bck = 1'b0, lrck = 1'b0, sdata = 1'b0;
    logic [2:0]  fmt = 3'd0;
    logic [23:0] left_o, right_o;
    logic        valid_o, sync_lost_o;

    pcm_serial_rx dut_i (
        .clk(clk), .rst_n(rst_n), .bck(bck), .lrck(lrck), .sdata(sdata),
        .fmt(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
        .sync_lost_o(sync_lost_o)
    );

    typedef struct { logic [23:0] l; logic [23:0] r; int idx; } exp_t;
    exp_t  expq[$];
    int    checks = 0, errors = 0;
    int    got = 0, first_idx = -1, last_idx = -1, loss_cnt = 0;
    bit    allow_loss = 1'b0, done = 1'b0, prev_valid = 1'b0;
    string tag = "R11";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // R2 code table, written from the requirement.
    function automatic int wlen_of(input logic [2:0] c);
        case (c)
            3'd0, 3'd2, 3'd5: return 24;
            3'd3, 3'd6:       return 20;
            default:          return 16;
        endcase
    endfunction

    function automatic int just_of(input logic [2:0] c); // 0 I2S, 1 left, 2 right
        if (c <= 3'd1) return 0;
        if (c <= 3'd4) return 1;
        return 2;
    endfunction

    function automatic logic [23:0] sext(input logic [23:0] w, input int n);
        int v;
        v = int'(w) & ((1 << n) - 1);
        if (((v >> (n - 1)) & 1) == 1) v = v - (1 << n);
        return v[23:0];
    endfunction

    // Per-clock comparison against the expected pair queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sync_lost_o) begin
                loss_cnt++;
                chk(allow_loss, "R9", "unexpected sync_lost", 48'd1, 48'd0);
            end
            if (valid_o) begin
                exp_t e;
                exp_t front;
                bit   found;
                found = 1'b0;
                front = (expq.size() > 0) ? expq[0] : '{24'h0, 24'h0, -1};
                chk(!prev_valid, "R7", "valid wider than one cycle", 48'd1, 48'd0);
                while (expq.size() > 0 && !found) begin
                    e = expq.pop_front();
                    if (e.l == left_o && e.r == right_o) found = 1'b1;
                end
                chk(found, {tag, " R1 R7"}, "pair", {left_o, right_o}, {front.l, front.r});
                if (found) begin
                    got++;
                    last_idx = e.idx;
                    if (first_idx < 0) first_idx = e.idx;
                end
            end
            prev_valid = valid_o;
        end
    end

    task automatic send_bit(input logic lv, input logic d);
        @(negedge clk);
        bck = 1'b0; lrck = lv; sdata = d;
        repeat (4) @(negedge clk);
        bck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input logic [2:0] code, input logic [23:0] lw,
                              input logic [23:0] rw, input int idx, input int extra);
        int n, j;
        logic lvl_left, lv, d;
        logic [23:0] w;
        n = wlen_of(code);
        j = just_of(code);
        lvl_left = (j == 0) ? 1'b0 : 1'b1;   // R3 R4 R5 polarity
        expq.push_back('{sext(lw, n), sext(rw, n), idx});
        for (int h = 0; h < 2; h++) begin
            w  = (h == 0) ? lw : rw;
            lv = (h == 0) ? lvl_left : ~lvl_left;
            for (int b = 0; b < 32; b++) begin
                d = 1'b0;
                if (j == 1 && b < n)               d = w[n - 1 - b];
                if (j == 0 && b >= 1 && b <= n)    d = w[n - b];
                if (j == 2 && b >= 32 - n)         d = w[31 - b];
                send_bit(lv, d);
            end
        end
        for (int x = 0; x < extra; x++) send_bit(~lvl_left, 1'b0);
    endtask

    task automatic reset_dut(input logic [2:0] code);
        fmt = code; rst_n = 1'b0; bck = 1'b0; lrck = 1'b0; sdata = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(left_o == 24'h0 && right_o == 24'h0 && !valid_o && !sync_lost_o,
            "R11", "reset outputs", {left_o, right_o}, 48'h0);
        expq.delete();
        got = 0; first_idx = -1; last_idx = -1; loss_cnt = 0; prev_valid = 1'b0;
    endtask

    function automatic logic [23:0] vec(input int k, input bit rt);
        logic [23:0] v;
        v = 24'h5A5A5A ^ 24'(k * 1267739);
        return rt ? ~v ^ 24'(k) : v;
    endfunction

    task automatic run_phase(input logic [2:0] code, input string t);
        int n;
        n = wlen_of(code);
        tag = t;
        reset_dut(code);
        for (int k = 0; k < 5; k++) begin
            if (k == 2) send_frame(code, 24'(1) << (n - 1), (24'(1) << (n - 1)) - 24'(1), k, 0);
            else        send_frame(code, vec(k, 1'b0), vec(k, 1'b1), k, 0);
        end
        send_frame(code, 24'h0F0F0F, 24'hF0F0F0, 5, 0);
        repeat (8) @(negedge clk);
        chk(got == 5, {t, " R7"}, "frames delivered", 48'(got), 48'd5);
        chk(first_idx == ((just_of(code) == 2) ? 0 : 1), "R11", "first delivered frame",
            48'(first_idx), 48'((just_of(code) == 2) ? 0 : 1));
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int base;
        run_phase(3'd0, "R2 R3");
        run_phase(3'd1, "R3 R6");
        run_phase(3'd2, "R4");
        run_phase(3'd3, "R4 R6");
        run_phase(3'd4, "R4 R6");
        run_phase(3'd5, "R5");
        run_phase(3'd6, "R5 R6");
        run_phase(3'd7, "R5 R6");

        // Drift: exactly six bit clocks tolerated, seven not.
        tag = "R9";
        reset_dut(3'd0);
        for (int k = 0; k < 4; k++) send_frame(3'd0, vec(k, 1'b0), vec(k, 1'b1), k, 0);
        send_frame(3'd0, vec(4, 1'b0), vec(4, 1'b1), 4, 6);
        send_frame(3'd0, vec(5, 1'b0), vec(5, 1'b1), 5, 0);
        send_frame(3'd0, vec(6, 1'b0), vec(6, 1'b1), 6, 0);
        send_frame(3'd0, vec(7, 1'b0), vec(7, 1'b1), 7, 1);
        chk(loss_cnt == 0, "R9", "loss within tolerance", 48'(loss_cnt), 48'd0);
        base = got;
        allow_loss = 1'b1;
        tag = "R8";
        send_frame(3'd0, vec(8, 1'b0), vec(8, 1'b1), 8, 0);
        allow_loss = 1'b0;
        chk(loss_cnt == 1, "R8", "sync_lost pulses", 48'(loss_cnt), 48'd1);
        chk(left_o == 24'h0 && right_o == 24'h0, "R8", "muted outputs",
            {left_o, right_o}, 48'h0);
        chk(got == base, "R8", "frames withheld", 48'(got), 48'(base));
        tag = "R10";
        send_frame(3'd0, vec(9, 1'b0), vec(9, 1'b1), 9, 0);
        repeat (8) @(negedge clk);
        chk(got == base + 1, "R10", "delivery resumed", 48'(got), 48'(base + 1));
        chk(last_idx == 9, "R10", "resumed frame index", 48'(last_idx), 48'd9);
        done = 1'b1;
        report();
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end

endmodule